// File: doc/BRIEF.md
# Floating-Point Vector Min/Max Reducer

This block collapses the lanes of one 128-bit vector register into a single scalar: the largest or the smallest lane value. Lanes hold half-precision (16-bit) or single-precision (32-bit) numbers. Two comparison styles are offered. The NaN-propagating style returns the default quiet NaN whenever a NaN takes part. The number-preferring style returns the numeric operand when the other operand is a lone quiet NaN.

The caller presents the raw instruction fields together with the vector and pulses `start`. These fields are the width select, the two-bit size field, the U bit, the four-bit opcode and the half-precision enable. The block decodes them and picks the lane format and count. It then runs a pairwise binary tree whose combining order never changes, so the way NaNs are absorbed or propagated is deterministic. One cycle later it raises `done` with a registered result. Half-precision results are zero-extended to 32 bits.

An illegal field combination raises `undef` and yields a zero result. A signalling NaN seen anywhere in the tree raises `invalid`.

The control is a two-state machine:
- ST_IDLE: nothing is being presented.
- ST_DONE: a result is presented with `done` high.

There are three transitions:
- ST_IDLE goes to ST_DONE on `start`.
- ST_DONE stays in ST_DONE on another `start` (back-to-back operation).
- ST_DONE returns to ST_IDLE when `start` is low.

Top module: `fp_lane_reducer`

## Requirements
- R1: Decode. With `u_bit`=0 and `fp16_en`=1 the lanes are half precision, whatever `size_fld[0]` holds. Otherwise the single-precision form applies, and it needs `u_bit`=1, `q_full`=1 and `size_fld[0]`=0. `opcode` must be 0xC or 0xF. Any other combination gives `undef`=1, `result`=0 and `invalid`=0.
- R2: `size_fld[1]`=1 selects minimum and `size_fld[1]`=0 selects maximum.
- R3: Lane count depends on the format and width. Half precision with `q_full`=1 uses 8 lanes over the full 128 bits. Half precision with `q_full`=0 uses 4 lanes from bits 63:0, and bits 127:64 have no effect. Single precision uses 4 lanes. Lane j occupies bits starting at j times the lane width.
- R4: A half-precision result appears in `result[15:0]` with `result[31:16]`=0.
- R5: Opcode 0xF (NaN-propagating): any combine with a NaN operand yields the default quiet NaN, 0x7E00 for half precision or 0x7FC00000 for single precision.
- R6: Opcode 0xC (number-preferring): a combine with exactly one quiet-NaN operand yields the other operand. Two NaN operands, or any signalling NaN, yield the default quiet NaN.
- R7: `invalid`=1 when any lane seen by the tree is a signalling NaN (exponent all ones, mantissa MSB 0, mantissa nonzero).
- R8: The tree combines lanes (0,1), (2,3) and so on, then pairs those results, lower half first. For example, a number-preferring minimum over half lanes {sNaN, 1.0, 2.0, 3.0} gives 2.0 (0x4000) with `invalid`=1.
- R9: Negative zero orders below positive zero. The maximum of ±0 is 0x0000 and the minimum is 0x8000 (half precision).
- R10: `done` rises exactly one cycle after `start`. It stays high for one cycle, or for longer while `start` repeats. `result`, `undef` and `invalid` hold until the next `start`.
- R11: After reset `done`, `result`, `undef` and `invalid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a reduction with the present inputs |
| vec_in | input | 128 | Source vector, lane 0 in the low bits |
| q_full | input | 1 | 1 = 128-bit source, 0 = 64-bit source |
| size_fld | input | 2 | Raw size field; bit 1 selects minimum |
| u_bit | input | 1 | Raw U bit of the encoding |
| opcode | input | 4 | 0xC number-preferring, 0xF NaN-propagating |
| fp16_en | input | 1 | Half-precision support enabled |
| result | output | 32 | Reduced scalar, zero-extended |
| undef | output | 1 | Undefined encoding flag |
| invalid | output | 1 | Signalling NaN encountered |
| done | output | 1 | Result valid |

## Verification
A new `start` can land in the same cycle in which the previous result is being presented with `done` high. In that cycle the machine must keep `done` asserted and swap in the next result without a gap. The bench drives two different reductions on consecutive cycles. It expects the first result while `start` is still high for the second operation, and the second result in the following cycle. It then expects `done` to fall with the second result held. A separate decode case also puts an illegal encoding straight after a legal one, to show that the `undef` flag and the zeroed result replace the earlier value cleanly.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
    localparam logic [3:0] OPC_NUMPREF = 4'hC;
    localparam logic [3:0] OPC_PROPAG  = 4'hF;

    typedef enum logic {ST_IDLE, ST_DONE} fsm_t;

    typedef struct packed {
        logic       legal;
        logic       half;
        logic       is_min;
        logic       num_pref;
        logic [5:0] var_code;
    } dec_t;
endpackage

// File: rtl/fpr_decode.sv
module fpr_decode
    import fpr_pkg::*;
(
    input  logic       q_full,
    input  logic [1:0] size_fld,
    input  logic       u_bit,
    input  logic [3:0] opcode,
    input  logic       fp16_en,
    output dec_t       dec
);
    logic opc_ok;

    always_comb begin
        opc_ok       = (opcode == OPC_NUMPREF) || (opcode == OPC_PROPAG);
        dec.is_min   = size_fld[1];
        dec.var_code = {u_bit, size_fld[1], opcode};
        dec.num_pref = (dec.var_code[3:0] == OPC_NUMPREF);
        dec.half     = !u_bit && fp16_en;
        if (!opc_ok) begin
            dec.legal = 1'b0;
        end else if (dec.half) begin
            dec.legal = 1'b1;
        end else begin
            dec.legal = u_bit && q_full && !size_fld[0];
        end
    end
endmodule

// File: rtl/fpr_minmax_cell.sv
module fpr_minmax_cell #(
    parameter int EW = 5,
    parameter int MW = 10
) (
    input  logic [EW+MW:0] a,
    input  logic [EW+MW:0] b,
    input  logic           is_min,
    input  logic           num_pref,
    output logic [EW+MW:0] y,
    output logic           sig
);
    localparam int W = 1 + EW + MW;
    localparam logic [W-1:0] DEF_QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

    logic a_nan, b_nan, a_snan, b_snan, any_snan, a_gt;
    logic [W-1:0] ka, kb, pick;

    always_comb begin
        a_nan    = (&a[W-2:MW]) && (|a[MW-1:0]);
        b_nan    = (&b[W-2:MW]) && (|b[MW-1:0]);
        a_snan   = a_nan && !a[MW-1];
        b_snan   = b_nan && !b[MW-1];
        any_snan = a_snan || b_snan;
        ka       = a[W-1] ? ~a : {1'b1, a[W-2:0]};
        kb       = b[W-1] ? ~b : {1'b1, b[W-2:0]};
        a_gt     = ka > kb;
        pick     = (a_gt ^ is_min) ? a : b;
        sig      = any_snan;
        if (!a_nan && !b_nan)
            y = pick;
        else if (num_pref && !any_snan && a_nan && !b_nan)
            y = b;
        else if (num_pref && !any_snan && b_nan && !a_nan)
            y = a;
        else
            y = DEF_QNAN;
    end
endmodule

// File: rtl/fpr_tree.sv
module fpr_tree #(
    parameter int EW    = 5,
    parameter int MW    = 10,
    parameter int LANES = 8,
    localparam int W     = 1 + EW + MW,
    localparam int NODES = 2 * LANES - 1
) (
    input  logic [LANES*W-1:0] lanes,
    input  logic               is_min,
    input  logic               num_pref,
    output logic [NODES*W-1:0] node_flat,
    output logic [NODES-1:0]   node_sig
);
    genvar i;
    generate
        for (i = 0; i < LANES; i++) begin : g_leaf
            assign node_flat[(LANES-1+i)*W +: W] = lanes[i*W +: W];
            assign node_sig[LANES-1+i]           = 1'b0;
        end
        for (i = 0; i < LANES - 1; i++) begin : g_cell
            logic cell_sig;
            fpr_minmax_cell #(.EW(EW), .MW(MW)) u_cell (
                .a        (node_flat[(2*i+1)*W +: W]),
                .b        (node_flat[(2*i+2)*W +: W]),
                .is_min   (is_min),
                .num_pref (num_pref),
                .y        (node_flat[i*W +: W]),
                .sig      (cell_sig)
            );
            assign node_sig[i] = cell_sig | node_sig[2*i+1] | node_sig[2*i+2];
        end
    endgenerate
endmodule

// File: rtl/fp_lane_reducer.sv
module fp_lane_reducer
    import fpr_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VEC_W-1:0] vec_in,
    input  logic             q_full,
    input  logic [1:0]       size_fld,
    input  logic             u_bit,
    input  logic [3:0]       opcode,
    input  logic             fp16_en,
    output logic [OUT_W-1:0] result,
    output logic             undef,
    output logic             invalid,
    output logic             done
);
    localparam int HW   = 16;
    localparam int SW   = 32;
    localparam int HL   = VEC_W / HW;
    localparam int SL   = VEC_W / SW;
    localparam int HN   = 2 * HL - 1;
    localparam int SN   = 2 * SL - 1;
    localparam int HALF_SUB = 1;

    dec_t dec;
    fsm_t state, state_nxt;
    logic [HN*HW-1:0] h_nodes;
    logic [HN-1:0]    h_sig;
    logic [SN*SW-1:0] s_nodes;
    logic [SN-1:0]    s_sig;
    logic [OUT_W-1:0] res_nxt;
    logic             inv_nxt;

    fpr_decode u_dec (
        .q_full   (q_full),
        .size_fld (size_fld),
        .u_bit    (u_bit),
        .opcode   (opcode),
        .fp16_en  (fp16_en),
        .dec      (dec)
    );

    fpr_tree #(.EW(5), .MW(10), .LANES(HL)) u_htree (
        .lanes     (vec_in),
        .is_min    (dec.is_min),
        .num_pref  (dec.num_pref),
        .node_flat (h_nodes),
        .node_sig  (h_sig)
    );

    fpr_tree #(.EW(8), .MW(23), .LANES(SL)) u_stree (
        .lanes     (vec_in),
        .is_min    (dec.is_min),
        .num_pref  (dec.num_pref),
        .node_flat (s_nodes),
        .node_sig  (s_sig)
    );

    always_comb begin
        res_nxt = '0;
        inv_nxt = 1'b0;
        if (dec.legal) begin
            if (dec.half) begin
                if (q_full) begin
                    res_nxt[HW-1:0] = h_nodes[0 +: HW];
                    inv_nxt         = h_sig[0];
                end else begin
                    res_nxt[HW-1:0] = h_nodes[HALF_SUB*HW +: HW];
                    inv_nxt         = h_sig[HALF_SUB];
                end
            end else begin
                res_nxt[SW-1:0] = s_nodes[0 +: SW];
                inv_nxt         = s_sig[0];
            end
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start) state_nxt = ST_DONE;
            ST_DONE: state_nxt = start ? ST_DONE : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result  <= '0;
            undef   <= 1'b0;
            invalid <= 1'b0;
        end else if (start) begin
            result  <= res_nxt;
            undef   <= !dec.legal;
            invalid <= inv_nxt;
        end
    end

    assign done = (state == ST_DONE);
endmodule

// File: rtl/fpr_checker.sv
module fpr_checker #(
    parameter int OUT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [OUT_W-1:0] result,
    input logic             undef,
    input logic             invalid,
    input logic             done
);
    // R10
    done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    // R10
    done_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));
    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(result) && $stable(undef) && $stable(invalid)));
    // R1
    undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> (result == '0 && !invalid));
endmodule

bind fp_lane_reducer fpr_checker #(.OUT_W(OUT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .result  (result),
    .undef   (undef),
    .invalid (invalid),
    .done    (done)
);

// File: tb/sim_fp_lane_reducer.sv
module sim_fp_lane_reducer;
    localparam int CLK_PERIOD = 10;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         start = 0;
    logic [127:0] vec_in = '0;
    logic         q_full = 0;
    logic [1:0]   size_fld = 0;
    logic         u_bit = 0;
    logic [3:0]   opcode = 0;
    logic         fp16_en = 0;
    logic [31:0]  result;
    logic         undef, invalid, done;
    int           n_chk = 0;
    int           n_fail = 0;
    bit           finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_lane_reducer u0 (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [127:0] h8(input logic [15:0] l0, l1, l2, l3, l4, l5, l6, l7);
        return {l7, l6, l5, l4, l3, l2, l1, l0};
    endfunction

    task automatic drive(input logic [127:0] v, input logic q, input logic [1:0] sz,
                         input logic u, input logic [3:0] opc, input logic f16);
        vec_in = v; q_full = q; size_fld = sz; u_bit = u; opcode = opc; fp16_en = f16;
        start = 1;
    endtask

    task automatic run(input logic [127:0] v, input logic q, input logic [1:0] sz,
                       input logic u, input logic [3:0] opc, input logic f16);
        @(negedge clk);
        drive(v, q, sz, u, opc, f16);
        @(negedge clk);
        start = 0;
    endtask

    task automatic t_reset();
        chk("R11 done", {31'b0, done}, 0);
        chk("R11 result", result, 0);
        chk("R11 undef", {31'b0, undef}, 0);
        chk("R11 invalid", {31'b0, invalid}, 0);
    endtask

    task automatic t_half_full();
        logic [127:0] v = h8(16'h3C00, 16'h4000, 16'h4200, 16'hBC00,
                             16'h3800, 16'h4400, 16'h0000, 16'h8000);
        run(v, 1, 2'b00, 0, 4'hF, 1);
        chk("R10 done", {31'b0, done}, 1);
        chk("R3 R4 half max 8 lanes", result, 32'h0000_4400);
        run(v, 1, 2'b10, 0, 4'hF, 1);
        chk("R2 half min 8 lanes", result, 32'h0000_BC00);
        run(v, 1, 2'b11, 0, 4'hC, 1);
        chk("R1 half ignores size0", {undef, result[30:0]}, 32'h0000_BC00);
    endtask

    task automatic t_half_q0();
        logic [127:0] v = h8(16'h3C00, 16'h4000, 16'h4200, 16'h3800,
                             16'h4400, 16'h7C00, 16'h7D00, 16'hFC00);
        run(v, 0, 2'b00, 0, 4'hF, 1);
        chk("R3 upper half ignored max", result, 32'h0000_4200);
        chk("R3 upper sNaN ignored", {31'b0, invalid}, 0);
    endtask

    task automatic t_single();
        logic [127:0] v = {32'h40A0_0000, 32'hC040_0000, 32'h4000_0000, 32'h3F80_0000};
        run(v, 1, 2'b00, 1, 4'hF, 1);
        chk("R2 single max", result, 32'h40A0_0000);
        run(v, 1, 2'b10, 1, 4'hC, 0);
        chk("R2 single min", result, 32'hC040_0000);
    endtask

    task automatic t_nan_prop();
        run(h8(16'h3C00, 16'h7E00, 16'h4000, 16'h4200, 0, 0, 0, 0), 0, 2'b00, 0, 4'hF, 1);
        chk("R5 half qNaN propagates", result, 32'h0000_7E00);
        chk("R7 qNaN not invalid", {31'b0, invalid}, 0);
        run({32'h4000_0000, 32'h7FC1_2345, 32'h0, 32'h3F80_0000}, 1, 2'b10, 1, 4'hF, 0);
        chk("R5 single qNaN propagates", result, 32'h7FC0_0000);
    endtask

    task automatic t_num_pref();
        logic [127:0] v = h8(16'h7D00, 16'h3C00, 16'h4000, 16'h4200, 0, 0, 0, 0);
        run(h8(16'h7E00, 16'h3C00, 16'h4000, 16'h4200, 0, 0, 0, 0), 0, 2'b00, 0, 4'hC, 1);
        chk("R6 qNaN dropped", result, 32'h0000_4200);
        run(v, 0, 2'b10, 0, 4'hC, 1);
        chk("R8 sNaN pair then number", result, 32'h0000_4000);
        chk("R7 sNaN invalid", {31'b0, invalid}, 1);
        run(v, 0, 2'b10, 0, 4'hF, 1);
        chk("R5 sNaN propagating", result, 32'h0000_7E00);
        run(h8(16'h7E00, 16'h7E01, 16'h7E00, 16'h7E00, 0, 0, 0, 0), 0, 2'b00, 0, 4'hC, 1);
        chk("R6 all qNaN", result, 32'h0000_7E00);
    endtask

    task automatic t_zero();
        run(h8(16'h8000, 16'h0000, 16'h8000, 16'h8000, 0, 0, 0, 0), 0, 2'b00, 0, 4'hF, 1);
        chk("R9 max zeros", result, 32'h0000_0000);
        run(h8(16'h0000, 16'h8000, 16'h0000, 16'h0000, 0, 0, 0, 0), 0, 2'b10, 0, 4'hC, 1);
        chk("R9 min zeros", result, 32'h0000_8000);
    endtask

    task automatic t_undef();
        logic [127:0] v = {32'h40A0_0000, 32'hC040_0000, 32'h7F80_0001, 32'h3F80_0000};
        run(v, 0, 2'b00, 1, 4'hF, 1);
        chk("R1 single q0 undef", {undef, result[30:0]}, 32'h8000_0000);
        chk("R1 undef no invalid", {31'b0, invalid}, 0);
        run(v, 1, 2'b00, 0, 4'hF, 0);
        chk("R1 u0 no fp16 undef", {undef, result[30:0]}, 32'h8000_0000);
        run(v, 1, 2'b01, 1, 4'hF, 1);
        chk("R1 size0 set undef", {31'b0, undef}, 1);
        run(v, 1, 2'b00, 0, 4'h5, 1);
        chk("R1 bad opcode undef", {31'b0, undef}, 1);
    endtask

    task automatic t_hold_and_b2b();
        logic [127:0] va = h8(16'h3C00, 16'h4000, 16'h4200, 16'h3800, 0, 0, 0, 0);
        logic [127:0] vb = h8(16'hBC00, 16'h4000, 16'h4200, 16'h3800, 0, 0, 0, 0);
        run(va, 0, 2'b00, 0, 4'hF, 1);
        repeat (3) @(negedge clk);
        chk("R10 done falls", {31'b0, done}, 0);
        chk("R10 result held", result, 32'h0000_4200);
        @(negedge clk);
        drive(va, 0, 2'b10, 0, 4'hF, 1);
        @(negedge clk);
        drive(vb, 0, 2'b10, 0, 4'hF, 1);
        chk("R10 b2b first", {done, result[30:0]}, 32'h8000_3800);
        @(negedge clk);
        start = 0;
        chk("R10 b2b second", {done, result[30:0]}, 32'h8000_BC00);
        @(negedge clk);
        chk("R10 b2b end", {done, result[30:0]}, 32'h0000_BC00);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_half_full();
        t_half_q0();
        t_single();
        t_nan_prop();
        t_num_pref();
        t_zero();
        t_undef();
        t_hold_and_b2b();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule